// File: doc/BRIEF.md
# USB Packet Direction Repeater Controller

This block sits between two low/full-speed USB D+/D- pairs, an upstream side facing the host and a downstream side facing the peripheral. Each pair reaches it as two digital samples. While the bus is quiet it drives neither side and watches both. The first side whose line leaves the idle J state becomes the source for the packet. The block then rebuilds that side's line state on the other side and enables only that side's drivers.

Forwarding stops when an end-of-packet is recognised or when the source has sat at J for a set number of bit times. The block then returns to watching both sides. Only J, K and SE0 are ever rebuilt. An SE1, or an SE0 that does not last until a bit-sampling tick, is dropped and the last valid state is held.

A single speed strap selects the J/K polarity. A bit-time tick input, one clock wide and placed mid-bit, supplies all timing. Analog transceivers, slew control and NRZI or bit-stuff decoding are handled outside this block.

Top module: `usb_dir_repeater`

## Requirements
- R1: Out of reset, and at any time a side is not being driven, that side's output enable is 0 and its D+/D- drive values are both 0.
- R2: From the monitoring state, the side whose filtered line state is first seen as anything other than J becomes the source. If both sides leave J in the same cycle, the upstream side wins.
- R3: While a packet is forwarded, only the destination side's output enable is 1. The destination side's own inputs have no effect on any output until the block returns to monitoring.
- R4: SE1 is never forwarded. An SE1 on an input is ignored, and the previously forwarded or idle state is held.
- R5: An SE0 on an input is accepted only if it is present in a cycle where bit_tick is 1. An SE0 that starts and ends between two ticks is ignored.
- R6: Pin encoding is (D+,D-): SE0 = (0,0). With fs_mode=1, J = (1,0) and K = (0,1). With fs_mode=0, J = (0,1) and K = (1,0). The same encoding applies to inputs and outputs.
- R7: An SE0 that covers at least two bit ticks, followed by J, is an end-of-packet. The destination keeps driving J until the second bit tick after the J is recognised, and then both output enables drop to 0.
- R8: If the source holds J for IDLE_TICKS bit ticks (default 8) without an end-of-packet, forwarding ends and both enables return to 0 at the tick that completes the count.
- R9: An SE0 that covers only one bit tick before J is not an end-of-packet. Forwarding continues, and only the idle timeout ends it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fs_mode | input | 1 | Speed strap: 1 = full-speed polarity, 0 = low-speed polarity |
| bit_tick | input | 1 | One-cycle pulse per bit time, placed mid-bit |
| up_dp_i | input | 1 | Sampled upstream D+ |
| up_dm_i | input | 1 | Sampled upstream D- |
| dn_dp_i | input | 1 | Sampled downstream D+ |
| dn_dm_i | input | 1 | Sampled downstream D- |
| up_dp_o | output | 1 | Upstream D+ drive value |
| up_dm_o | output | 1 | Upstream D- drive value |
| up_oe | output | 1 | Upstream output enable |
| dn_dp_o | output | 1 | Downstream D+ drive value |
| dn_dm_o | output | 1 | Downstream D- drive value |
| dn_oe | output | 1 | Downstream output enable |

## Verification
The bench drives garbage on the destination inputs during each packet. A design that looped the destination back would turn the bus around or corrupt the stream. It places one-cycle SE0 pulses between ticks and full bits of SE1 both mid-packet and on an idle bus. A filter that let either through would forward an invalid state or start a phantom packet. It contrasts a one-tick SE0 with a two-tick SE0 and measures release times at bit boundaries. A design that took a short SE0 as an end-of-packet, released at the first tick, or mis-counted the idle window would release one bit early or one bit late. It also drives a same-cycle departure on both sides and a low-speed downstream packet, which expose a wrong tie priority and swapped J/K polarity.

// File: rtl/usbrep_pkg.sv
// Shared types and pin-encoding helpers for the USB direction repeater.
// Assumes the (D+,D-) sample pair is already synchronised to clk.
package usbrep_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'd0,
        LS_J   = 2'd1,
        LS_K   = 2'd2,
        LS_SE1 = 2'd3
    } line_t;

    typedef enum logic [1:0] {
        ST_MON = 2'd0,
        ST_FWD = 2'd1,
        ST_EOP = 2'd2
    } rep_st_t;

    // Map a pin pair {dp,dm} to a line state under the selected polarity.
    function automatic line_t pins_to_ls(input logic [1:0] pins, input logic fs);
        line_t ls;
        case (pins)
            2'b00:   ls = LS_SE0;
            2'b11:   ls = LS_SE1;
            2'b10:   ls = fs ? LS_J : LS_K;
            default: ls = fs ? LS_K : LS_J;
        endcase
        return ls;
    endfunction

    // Map a line state to a pin pair {dp,dm} under the selected polarity.
    function automatic logic [1:0] ls_to_pins(input line_t ls, input logic fs);
        logic [1:0] pins;
        case (ls)
            LS_J:    pins = fs ? 2'b10 : 2'b01;
            LS_K:    pins = fs ? 2'b01 : 2'b10;
            LS_SE1:  pins = 2'b11;
            default: pins = 2'b00;
        endcase
        return pins;
    endfunction

endpackage

// File: rtl/usbrep_line_codec.sv
// Turns one sampled (D+,D-) pair into a line state.
// Purely combinational; polarity comes from the speed strap.
module usbrep_line_codec
    import usbrep_pkg::*;
(
    input  logic  dp,
    input  logic  dm,
    input  logic  fs_mode,
    output line_t ls
);

    // Decode the pin pair.
    always_comb begin
        ls = pins_to_ls({dp, dm}, fs_mode);
    end

endmodule

// File: rtl/usbrep_se_filter.sv
// Keeps only valid line states for one side.
// J and K pass on the next clock. SE1 is ignored. SE0 is taken only in a
// cycle where bit_tick is high. Also counts the ticks the current SE0 run
// has covered (saturating), for end-of-packet recognition.
// Assumes bit_tick is one clock wide and placed mid-bit.
module usbrep_se_filter
    import usbrep_pkg::*;
#(
    parameter int RUN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  line_t            raw,
    output line_t            filt,
    output logic [RUN_W-1:0] se0_run
);

    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

    // Register the filtered state and the SE0 tick run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt    <= LS_J;
            se0_run <= '0;
        end else begin
            case (raw)
                LS_J, LS_K: begin
                    filt    <= raw;
                    se0_run <= '0;
                end
                LS_SE0: begin
                    if (bit_tick) begin
                        filt <= LS_SE0;
                        if (se0_run != RUN_MAX) begin
                            se0_run <= se0_run + 1'b1;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/usbrep_dir_ctrl.sv
// Packet direction controller and output rebuilder.
// In monitoring it drives nothing and picks the first side that leaves J
// as the source (upstream wins a tie). It then copies the source's filtered
// state to the other side. It ends the packet on SE0 (two or more ticks)
// followed by J, with J held until the second tick, or after IDLE_TICKS
// ticks of J. Assumes filtered inputs never carry SE1.
module usbrep_dir_ctrl
    import usbrep_pkg::*;
#(
    parameter int IDLE_TICKS = 8,
    parameter int RUN_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             fs_mode,
    input  line_t            up_filt,
    input  logic [RUN_W-1:0] up_run,
    input  line_t            dn_filt,
    input  logic [RUN_W-1:0] dn_run,
    output logic             up_oe,
    output logic             up_dp_o,
    output logic             up_dm_o,
    output logic             dn_oe,
    output logic             dn_dp_o,
    output logic             dn_dm_o
);

    localparam int CW = (IDLE_TICKS > 1) ? $clog2(IDLE_TICKS) : 1;
    localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_TICKS - 1);
    localparam logic [RUN_W-1:0] EOP_RUN = RUN_W'(2);

    rep_st_t          st;
    logic             to_dn;      // 1: upstream is the source
    logic             out_en;
    line_t            out_ls;
    logic             eop_seen;
    logic             eop_half;
    logic [CW-1:0]    idle_cnt;
    line_t            src_ls;
    logic [RUN_W-1:0] src_run;
    logic [1:0]       pins;

    // Select the source side's filtered state and SE0 run length.
    always_comb begin
        src_ls  = to_dn ? up_filt : dn_filt;
        src_run = to_dn ? up_run  : dn_run;
    end

    // Sequence monitoring, forwarding and end-of-packet hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_MON;
            to_dn    <= 1'b0;
            out_en   <= 1'b0;
            out_ls   <= LS_J;
            eop_seen <= 1'b0;
            eop_half <= 1'b0;
            idle_cnt <= '0;
        end else begin
            case (st)
                ST_MON: begin
                    eop_seen <= 1'b0;
                    eop_half <= 1'b0;
                    idle_cnt <= '0;
                    if (up_filt != LS_J) begin
                        st     <= ST_FWD;
                        to_dn  <= 1'b1;
                        out_en <= 1'b1;
                        out_ls <= up_filt;
                    end else if (dn_filt != LS_J) begin
                        st     <= ST_FWD;
                        to_dn  <= 1'b0;
                        out_en <= 1'b1;
                        out_ls <= dn_filt;
                    end else begin
                        out_en <= 1'b0;
                    end
                end
                ST_FWD: begin
                    out_ls <= src_ls;
                    case (src_ls)
                        LS_SE0: begin
                            idle_cnt <= '0;
                            if (src_run >= EOP_RUN) begin
                                eop_seen <= 1'b1;
                            end
                        end
                        LS_J: begin
                            if (eop_seen) begin
                                st       <= ST_EOP;
                                eop_seen <= 1'b0;
                                eop_half <= 1'b0;
                            end else if (bit_tick) begin
                                if (idle_cnt == IDLE_LAST) begin
                                    st       <= ST_MON;
                                    out_en   <= 1'b0;
                                    idle_cnt <= '0;
                                end else begin
                                    idle_cnt <= idle_cnt + 1'b1;
                                end
                            end
                        end
                        default: begin
                            idle_cnt <= '0;
                            eop_seen <= 1'b0;
                        end
                    endcase
                end
                ST_EOP: begin
                    out_ls <= LS_J;
                    if (bit_tick) begin
                        if (eop_half) begin
                            st       <= ST_MON;
                            out_en   <= 1'b0;
                            eop_half <= 1'b0;
                        end else begin
                            eop_half <= 1'b1;
                        end
                    end
                end
                default: begin
                    st     <= ST_MON;
                    out_en <= 1'b0;
                end
            endcase
        end
    end

    // Encode the rebuilt state and gate it onto the destination side.
    always_comb begin
        pins    = ls_to_pins(out_ls, fs_mode);
        up_oe   = out_en & ~to_dn;
        dn_oe   = out_en & to_dn;
        up_dp_o = up_oe & pins[1];
        up_dm_o = up_oe & pins[0];
        dn_dp_o = dn_oe & pins[1];
        dn_dm_o = dn_oe & pins[0];
    end

endmodule

// File: rtl/usb_dir_repeater.sv
// Top of the USB packet direction repeater: per-side decode and filter,
// then the shared direction controller. Index 0 is upstream, 1 downstream.
// Assumes all inputs are synchronous to clk.
module usb_dir_repeater
    import usbrep_pkg::*;
#(
    parameter int IDLE_TICKS = 8,
    parameter int N_SIDES    = 2,
    parameter int RUN_W      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_mode,
    input  logic bit_tick,
    input  logic up_dp_i,
    input  logic up_dm_i,
    input  logic dn_dp_i,
    input  logic dn_dm_i,
    output logic up_dp_o,
    output logic up_dm_o,
    output logic up_oe,
    output logic dn_dp_o,
    output logic dn_dm_o,
    output logic dn_oe
);

    logic [N_SIDES-1:0] side_dp;
    logic [N_SIDES-1:0] side_dm;
    line_t              raw_ls  [N_SIDES];
    line_t              filt_ls [N_SIDES];
    logic [RUN_W-1:0]   run_len [N_SIDES];
    line_t              up_raw, dn_raw, up_filt, dn_filt;

    // Gather the side pins into indexed vectors.
    always_comb begin
        side_dp = {dn_dp_i, up_dp_i};
        side_dm = {dn_dm_i, up_dm_i};
    end

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        usbrep_line_codec u_codec (
            .dp      (side_dp[s]),
            .dm      (side_dm[s]),
            .fs_mode (fs_mode),
            .ls      (raw_ls[s])
        );
        usbrep_se_filter #(.RUN_W(RUN_W)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .bit_tick (bit_tick),
            .raw      (raw_ls[s]),
            .filt     (filt_ls[s]),
            .se0_run  (run_len[s])
        );
    end

    // Name the per-side states for the controller and the checker.
    always_comb begin
        up_raw  = raw_ls[0];
        dn_raw  = raw_ls[1];
        up_filt = filt_ls[0];
        dn_filt = filt_ls[1];
    end

    usbrep_dir_ctrl #(.IDLE_TICKS(IDLE_TICKS), .RUN_W(RUN_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .fs_mode  (fs_mode),
        .up_filt  (up_filt),
        .up_run   (run_len[0]),
        .dn_filt  (dn_filt),
        .dn_run   (run_len[1]),
        .up_oe    (up_oe),
        .up_dp_o  (up_dp_o),
        .up_dm_o  (up_dm_o),
        .dn_oe    (dn_oe),
        .dn_dp_o  (dn_dp_o),
        .dn_dm_o  (dn_dm_o)
    );

endmodule

// File: rtl/usbrep_checker.sv
// Property checker for usb_dir_repeater, attached with bind below.
module usbrep_checker
    import usbrep_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  bit_tick,
    input line_t up_raw,
    input line_t dn_raw,
    input line_t up_filt,
    input line_t dn_filt,
    input logic  up_oe,
    input logic  up_dp_o,
    input logic  up_dm_o,
    input logic  dn_oe,
    input logic  dn_dp_o,
    input logic  dn_dm_o
);

    // R3: never drive both sides at once
    a_r3_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_oe && dn_oe));

    // R1: a side that is not enabled carries zero drive values
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_oe |-> (!up_dp_o && !up_dm_o)) and (!dn_oe |-> (!dn_dp_o && !dn_dm_o)));

    // R4: SE1 never appears on an enabled side
    a_r4_no_se1: assert property (@(posedge clk) disable iff (!rst_n)
        (up_oe |-> !(up_dp_o && up_dm_o)) and (dn_oe |-> !(dn_dp_o && dn_dm_o)));

    // R2: a side starts driving only after the other side left J
    a_r2_dn_from_up: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_oe) |-> $past(up_filt) != LS_J);
    a_r2_up_from_dn: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_oe) |-> $past(dn_filt) != LS_J);

    // R5: a filtered SE0 begins only from a raw SE0 seen at a bit tick
    a_r5_up_se0_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (up_filt == LS_SE0 && $past(up_filt) != LS_SE0) |->
            ($past(bit_tick) && $past(up_raw) == LS_SE0));
    a_r5_dn_se0_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_filt == LS_SE0 && $past(dn_filt) != LS_SE0) |->
            ($past(bit_tick) && $past(dn_raw) == LS_SE0));

endmodule

bind usb_dir_repeater usbrep_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .up_raw   (up_raw),
    .dn_raw   (dn_raw),
    .up_filt  (up_filt),
    .dn_filt  (dn_filt),
    .up_oe    (up_oe),
    .up_dp_o  (up_dp_o),
    .up_dm_o  (up_dm_o),
    .dn_oe    (dn_oe),
    .dn_dp_o  (dn_dp_o),
    .dn_dm_o  (dn_dm_o)
);

// File: tb/tb_usb_dir_repeater.sv
// Scoreboard bench: stimulus tasks queue the expected output vectors
// {up_oe,up_dp,up_dm,dn_oe,dn_dp,dn_dm}; a monitor pops one per change.
module tb_usb_dir_repeater;
    import usbrep_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fs_mode = 1'b1;
    logic bit_tick = 1'b0;
    logic up_dp_i, up_dm_i, dn_dp_i, dn_dm_i;
    logic up_dp_o, up_dm_o, up_oe, dn_dp_o, dn_dm_o, dn_oe;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [5:0] exp_q[$];
    string tag_q[$];
    logic [5:0] last_vec = 6'b0;

    always #2 clk = ~clk;

    usb_dir_repeater #(.IDLE_TICKS(8)) dut (
        .clk(clk), .rst_n(rst_n), .fs_mode(fs_mode), .bit_tick(bit_tick),
        .up_dp_i(up_dp_i), .up_dm_i(up_dm_i), .dn_dp_i(dn_dp_i), .dn_dm_i(dn_dm_i),
        .up_dp_o(up_dp_o), .up_dm_o(up_dm_o), .up_oe(up_oe),
        .dn_dp_o(dn_dp_o), .dn_dm_o(dn_dm_o), .dn_oe(dn_oe)
    );

    // Encoding from R6, written independently of the design.
    function automatic logic [1:0] enc(line_t s, logic fs);
        case (s)
            LS_J:    return fs ? 2'b10 : 2'b01;
            LS_K:    return fs ? 2'b01 : 2'b10;
            LS_SE1:  return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_dn(line_t s, string req);
        exp_q.push_back({3'b000, 1'b1, enc(s, fs_mode)});
        tag_q.push_back(req);
    endtask

    task automatic push_up(line_t s, string req);
        exp_q.push_back({1'b1, enc(s, fs_mode), 3'b000});
        tag_q.push_back(req);
    endtask

    task automatic push_off(string req);
        exp_q.push_back(6'b000000);
        tag_q.push_back(req);
    endtask

    // One bit time: four clocks, tick in the third.
    task automatic drive_bit(line_t u, line_t d);
        {up_dp_i, up_dm_i} = enc(u, fs_mode);
        {dn_dp_i, dn_dm_i} = enc(d, fs_mode);
        for (int k = 0; k < 4; k++) begin
            bit_tick = (k == 2);
            @(negedge clk);
        end
        bit_tick = 1'b0;
    endtask

    // One bit of state base on upstream with a one-clock glitch at its start.
    task automatic glitch_bit(line_t base, line_t g, line_t d);
        {up_dp_i, up_dm_i} = enc(g, fs_mode);
        {dn_dp_i, dn_dm_i} = enc(d, fs_mode);
        bit_tick = 1'b0;
        @(negedge clk);
        {up_dp_i, up_dm_i} = enc(base, fs_mode);
        for (int k = 1; k < 4; k++) begin
            bit_tick = (k == 2);
            @(negedge clk);
        end
        bit_tick = 1'b0;
    endtask

    task automatic do_reset(logic fs);
        rst_n = 1'b0;
        fs_mode = fs;
        {up_dp_i, up_dm_i} = enc(LS_J, fs);
        {dn_dp_i, dn_dm_i} = enc(LS_J, fs);
        bit_tick = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 reset outputs", {up_oe, up_dp_o, up_dm_o, dn_oe, dn_dp_o, dn_dm_o}, 0);
    endtask

    // Monitor: each output change must match the next queued vector.
    always @(negedge clk) begin
        logic [5:0] cur;
        logic [5:0] e;
        string t;
        cur = {up_oe, up_dp_o, up_dm_o, dn_oe, dn_dp_o, dn_dm_o};
        if (!rst_n) begin
            last_vec = 6'b0;
        end else if (cur !== last_vec) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R3 unexpected output change actual=%0h expected=%0h", cur, last_vec);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, int'(cur), int'(e));
            end
            last_vec = cur;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);

        // Upstream packet with looped-back garbage, glitches and EOP (R3,R4,R5,R6,R7)
        push_dn(LS_K, "R6 fs K");   drive_bit(LS_K, LS_J);
        push_dn(LS_J, "R6 fs J");   drive_bit(LS_J, LS_K);
        push_dn(LS_K, "R3 K");      drive_bit(LS_K, LS_SE0);
        glitch_bit(LS_K, LS_SE0, LS_K);
        drive_bit(LS_SE1, LS_SE1);
        chk("R4 SE1 held as K", dn_dp_o ? 0 : 1, enc(LS_K, 1'b1) == {dn_dp_o, dn_dm_o} ? 1 : 0);
        push_dn(LS_SE0, "R7 SE0");  drive_bit(LS_SE0, LS_J);
        drive_bit(LS_SE0, LS_J);
        push_dn(LS_J, "R7 EOP J");
        push_off("R7 release");
        drive_bit(LS_J, LS_J);
        chk("R7 J held one bit", dn_oe, 1);
        drive_bit(LS_J, LS_J);
        chk("R7 released after second tick", dn_oe, 0);

        // Idle bus: SE1 bit and short SE0 must not start a packet (R4,R5)
        drive_bit(LS_SE1, LS_J);
        chk("R4 idle SE1 ignored", up_oe | dn_oe, 0);
        glitch_bit(LS_J, LS_SE0, LS_J);
        drive_bit(LS_J, LS_J);
        chk("R5 short SE0 ignored", up_oe | dn_oe, 0);

        // Both sides leave J together: upstream wins (R2)
        push_dn(LS_K, "R2 tie upstream"); drive_bit(LS_K, LS_K);
        push_dn(LS_SE0, "R2 SE0");        drive_bit(LS_SE0, LS_K);
        drive_bit(LS_SE0, LS_J);
        push_dn(LS_J, "R2 EOP J");
        push_off("R2 release");
        drive_bit(LS_J, LS_J);
        drive_bit(LS_J, LS_J);
        chk("R2 tie ended", up_oe | dn_oe, 0);

        // One-tick SE0 is not EOP; idle timeout ends packet (R8,R9)
        push_dn(LS_K, "R9 K");     drive_bit(LS_K, LS_J);
        push_dn(LS_SE0, "R9 SE0"); drive_bit(LS_SE0, LS_J);
        push_dn(LS_J, "R9 J");
        for (int b = 0; b < 7; b++) drive_bit(LS_J, LS_J);
        chk("R9 short SE0 not EOP", dn_oe, 1);
        chk("R8 no early timeout", dn_oe, 1);
        push_off("R8 timeout");
        drive_bit(LS_J, LS_J);
        chk("R8 released at eighth tick", dn_oe, 0);

        // Low-speed polarity, downstream source (R2,R6,R7)
        do_reset(1'b0);
        push_up(LS_K, "R6 ls K");   drive_bit(LS_J, LS_K);
        push_up(LS_J, "R6 ls J");   drive_bit(LS_K, LS_J);
        push_up(LS_SE0, "R7 ls SE0"); drive_bit(LS_SE0, LS_SE0);
        drive_bit(LS_J, LS_SE0);
        push_up(LS_J, "R7 ls EOP J");
        push_off("R7 ls release");
        drive_bit(LS_J, LS_J);
        chk("R2 downstream source drives upstream", up_oe, 1);
        drive_bit(LS_J, LS_J);
        chk("R7 ls released", up_oe, 0);

        repeat (3) drive_bit(LS_J, LS_J);
        chk("R1 all expected changes seen", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule